// File: doc/BRIEF.md
# Converter Calibration and Conversion Sequencer

This block is the control sequencer of a two-channel delta-sigma analog-to-digital converter. Two level inputs drive it: a calibrate request and a convert request. A rising edge on the convert request, qualified by the calibrate level, starts either a self-calibration or a conversion. The block captures the channel address at that edge. It times every phase by counting master clock cycles. When a result is finished it pulls the active-low data-ready output low. The filter result that goes out is formatted as unipolar (unchanged) or bipolar (mid-scale offset added). The filter delivers its 20-bit word with a strobe, and the block holds the latest such word until a conversion completes.

There are three states. `SEQ_IDLE` is standby. `SEQ_CAL` is self-calibration. `SEQ_CONV` is conversion. The transitions are:
- **start-cal**: IDLE to CAL, on a convert edge while calibrate is high.
- **start-conv**: IDLE to CONV, on a convert edge while calibrate is low.
- **restart-cal**: CAL to CAL, on a convert edge while calibrate is high.
- **cal-to-conv**: CAL to CONV, at the end of calibration while convert is high.
- **cal-to-idle**: CAL to IDLE, at the end of calibration while convert is low.
- **repeat-conv**: CONV to CONV, at the end of a conversion while convert is high.
- **conv-to-idle**: CONV to IDLE, at the end of a conversion while convert is low.

The convert, calibrate and address inputs pass through a two-stage synchroniser.

Top module: `adc_seq_ctrl`

## Requirements
- R1: From standby, a rising edge on `cnv_req` makes the block busy on the third rising clock edge after the input rises. It goes to calibration (`cal_busy`=1) if `cal_req` is high, and to conversion (`conv_busy`=1) if `cal_req` is low.
- R2: A calibration keeps `cal_busy` high for exactly 3246 clock cycles, counted from its start.
- R3: When calibration ends, the block enters a conversion if `cnv_req` is high, and returns to standby if `cnv_req` is low.
- R4: During calibration, a new rising edge on `cnv_req` while `cal_req` is high abandons the running calibration. A fresh one of 3246 cycles starts at that edge, with the same three-edge latency as R1.
- R5: During calibration, a rising edge on `cnv_req` while `cal_req` is low has no effect. The calibration length and `ch_sel` are unchanged.
- R6: `ch_sel` takes the value of `addr` at each accepted convert edge (start-cal, start-conv, restart-cal). Value 0 selects input 1 and value 1 selects input 2.
- R7: A conversion entered from standby or from calibration lasts 1624 cycles. A conversion that follows directly on another lasts 1622 cycles.
- R8: `drdy_n` falls on the clock edge that ends each conversion, including the first conversion after a calibration. It rises on the next edge after a conversion begins. Otherwise it holds its value. `res_out` changes only on the edge where `drdy_n` falls.
- R9: At the end of a conversion, `res_out` is the last filter word strobed by `flt_vld`, plus 0x80000 modulo 2^20 if `bipolar` was 1 on the clock edge 82 cycles before `drdy_n` falls. The word is passed unchanged if `bipolar` was 0 on that edge.
- R10: Lowering `cal_req` after a calibration has started does not change that calibration's length.
- R11: During and right after reset, `drdy_n`=1, `cal_busy`=0, `conv_busy`=0, `ch_sel`=0 and `res_out`=0.
- R12: Rising edges on `cnv_req` during a conversion are ignored. The conversion length and `ch_sel` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cal_req | input | 1 | calibrate request level |
| cnv_req | input | 1 | convert request level |
| addr | input | 1 | channel address, captured on an accepted convert edge |
| bipolar | input | 1 | 1 = bipolar output format, 0 = unipolar |
| flt_data | input | 20 | filter result word |
| flt_vld | input | 1 | strobe marking `flt_data` valid |
| ch_sel | output | 1 | selected input: 0 = input 1, 1 = input 2 |
| cal_busy | output | 1 | calibration in progress |
| conv_busy | output | 1 | conversion in progress |
| drdy_n | output | 1 | active-low data ready |
| res_out | output | 20 | formatted result word |

## Verification
A wrong state shows at `cal_busy` or `conv_busy` on the very next clock edge. A wrong phase counter or length selection shows at the phase boundary, as a busy interval 2 to thousands of cycles off, or as a `drdy_n` fall at the wrong cycle. A mistaken restart or ignore decision stretches or fails to stretch the calibration interval. A format sampled at the wrong cycle flips the top bit of `res_out`, visible the moment `drdy_n` falls.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_CAL  = 2'd1,
        SEQ_CONV = 2'd2
    } seq_state_e;

    localparam int unsigned DEF_DATA_W      = 20;
    localparam int unsigned DEF_CAL_CYCLES  = 3246;
    localparam int unsigned DEF_CONV_FIRST  = 1624;
    localparam int unsigned DEF_CONV_CONT   = 1622;
    localparam int unsigned DEF_MODE_LEAD   = 82;
    localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnv_i,
    input  logic cal_i,
    input  logic addr_i,
    output logic cnv_lvl,
    output logic cal_lvl,
    output logic addr_lvl,
    output logic cnv_rise
);
    localparam int unsigned TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] cnv_sh;
    logic [SYNC_STAGES-1:0] cal_sh;
    logic [SYNC_STAGES-1:0] addr_sh;
    logic                   cnv_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnv_sh   <= '0;
            cal_sh   <= '0;
            addr_sh  <= '0;
            cnv_prev <= 1'b0;
        end else begin
            cnv_sh   <= {cnv_sh[SYNC_STAGES-2:0], cnv_i};
            cal_sh   <= {cal_sh[SYNC_STAGES-2:0], cal_i};
            addr_sh  <= {addr_sh[SYNC_STAGES-2:0], addr_i};
            cnv_prev <= cnv_sh[TOP];
        end
    end

    assign cnv_lvl  = cnv_sh[TOP];
    assign cal_lvl  = cal_sh[TOP];
    assign addr_lvl = addr_sh[TOP];
    assign cnv_rise = cnv_sh[TOP] & ~cnv_prev;
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt #(
    parameter int unsigned DATA_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] res_i,
    input  logic              res_vld,
    input  logic              bp_i,
    input  logic              mode_take,
    input  logic              load,
    output logic [DATA_W-1:0] dout
);
    localparam logic [DATA_W-1:0] BIP_OFS = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] res_q;
    logic              mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '0;
            mode_q <= 1'b0;
            dout   <= '0;
        end else begin
            if (res_vld) begin
                res_q <= res_i;
            end
            if (mode_take) begin
                mode_q <= bp_i;
            end
            if (load) begin
                dout <= res_q + (mode_q ? BIP_OFS : '0);
            end
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned DATA_W      = DEF_DATA_W,
    parameter int unsigned CAL_CYCLES  = DEF_CAL_CYCLES,
    parameter int unsigned CONV_FIRST  = DEF_CONV_FIRST,
    parameter int unsigned CONV_CONT   = DEF_CONV_CONT,
    parameter int unsigned MODE_LEAD   = DEF_MODE_LEAD,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_req,
    input  logic              cnv_req,
    input  logic              addr,
    input  logic              bipolar,
    input  logic [DATA_W-1:0] flt_data,
    input  logic              flt_vld,
    output logic              ch_sel,
    output logic              cal_busy,
    output logic              conv_busy,
    output logic              drdy_n,
    output logic [DATA_W-1:0] res_out
);
    localparam int unsigned LONG_A  = (CAL_CYCLES > CONV_FIRST) ? CAL_CYCLES : CONV_FIRST;
    localparam int unsigned LONGEST = (LONG_A > CONV_CONT) ? LONG_A : CONV_CONT;
    localparam int unsigned CNT_W   = $clog2(LONGEST);

    localparam logic [CNT_W-1:0] CAL_LAST   = CNT_W'(CAL_CYCLES - 1);
    localparam logic [CNT_W-1:0] FIRST_LAST = CNT_W'(CONV_FIRST - 1);
    localparam logic [CNT_W-1:0] CONT_LAST  = CNT_W'(CONV_CONT - 1);
    localparam logic [CNT_W-1:0] FIRST_TAKE = CNT_W'(CONV_FIRST - 1 - MODE_LEAD);
    localparam logic [CNT_W-1:0] CONT_TAKE  = CNT_W'(CONV_CONT - 1 - MODE_LEAD);

    seq_state_e       state;
    seq_state_e       state_nx;
    logic             first_q;
    logic             first_nx;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             ch_take;
    logic             conv_done;
    logic             period_end;
    logic             mode_take;
    logic             cnv_lvl;
    logic             cal_lvl;
    logic             addr_lvl;
    logic             cnv_rise;

    adc_seq_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnv_i    (cnv_req),
        .cal_i    (cal_req),
        .addr_i   (addr),
        .cnv_lvl  (cnv_lvl),
        .cal_lvl  (cal_lvl),
        .addr_lvl (addr_lvl),
        .cnv_rise (cnv_rise)
    );

    adc_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    // Phase end and format sampling point depend on state and first-flag.
    always_comb begin
        if (state == SEQ_CAL) begin
            period_end = (cnt == CAL_LAST);
        end else begin
            period_end = first_q ? (cnt == FIRST_LAST) : (cnt == CONT_LAST);
        end
        mode_take = (state == SEQ_CONV) &&
                    (first_q ? (cnt == FIRST_TAKE) : (cnt == CONT_TAKE));
    end

    // Next-state and transition decode.
    always_comb begin
        state_nx  = state;
        first_nx  = first_q;
        cnt_clr   = 1'b0;
        ch_take   = 1'b0;
        conv_done = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                cnt_clr = 1'b1;
                if (cnv_rise) begin
                    ch_take = 1'b1;
                    if (cal_lvl) begin
                        state_nx = SEQ_CAL;                 // start-cal
                    end else begin
                        state_nx = SEQ_CONV;                // start-conv
                        first_nx = 1'b1;
                    end
                end
            end
            SEQ_CAL: begin
                if (cnv_rise && cal_lvl) begin
                    ch_take = 1'b1;                         // restart-cal
                    cnt_clr = 1'b1;
                end else if (period_end) begin
                    cnt_clr = 1'b1;
                    if (cnv_lvl) begin
                        state_nx = SEQ_CONV;                // cal-to-conv
                        first_nx = 1'b1;
                    end else begin
                        state_nx = SEQ_IDLE;                // cal-to-idle
                    end
                end
            end
            SEQ_CONV: begin
                if (period_end) begin
                    conv_done = 1'b1;
                    cnt_clr   = 1'b1;
                    if (cnv_lvl) begin
                        first_nx = 1'b0;                    // repeat-conv
                    end else begin
                        state_nx = SEQ_IDLE;                // conv-to-idle
                    end
                end
            end
            default: begin
                state_nx = SEQ_IDLE;
                cnt_clr  = 1'b1;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            first_q <= 1'b1;
        end else begin
            state   <= state_nx;
            first_q <= first_nx;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drdy_n <= 1'b1;
            ch_sel <= 1'b0;
        end else begin
            if (conv_done) begin
                drdy_n <= 1'b0;
            end else if ((state == SEQ_CONV) && (cnt == '0)) begin
                drdy_n <= 1'b1;
            end
            if (ch_take) begin
                ch_sel <= addr_lvl;
            end
        end
    end

    adc_seq_fmt #(.DATA_W(DATA_W)) u_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_i     (flt_data),
        .res_vld   (flt_vld),
        .bp_i      (bipolar),
        .mode_take (mode_take),
        .load      (conv_done),
        .dout      (res_out)
    );

    assign cal_busy  = (state == SEQ_CAL);
    assign conv_busy = (state == SEQ_CONV);
endmodule

// File: rtl/adc_seq_ctrl_sva.sv
module adc_seq_ctrl_sva #(
    parameter int unsigned DATA_W     = 20,
    parameter int unsigned CNT_W      = 12,
    parameter int unsigned CAL_LAST   = 3245,
    parameter int unsigned FIRST_LAST = 1623,
    parameter int unsigned CONT_LAST  = 1621
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cal_busy,
    input logic              conv_busy,
    input logic              drdy_n,
    input logic              ch_sel,
    input logic [DATA_W-1:0] res_out,
    input logic [CNT_W-1:0]  cnt
);
    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_busy && conv_busy));                                          // R1

    AST_CAL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_busy) |-> ($past(cnt) == CNT_W'(CAL_LAST)));              // R2

    AST_CH_HELD_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && $past(conv_busy)) |-> $stable(ch_sel));              // R12

    AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy_n) |-> ($past(cnt) == CNT_W'(FIRST_LAST) ||
                           $past(cnt) == CNT_W'(CONT_LAST)));               // R7

    AST_READY_FROM_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy_n) |-> $past(conv_busy));                                // R8

    AST_READY_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (!drdy_n && conv_busy) |=> drdy_n);                                 // R8

    AST_RESULT_ONLY_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_out) |-> $fell(drdy_n));                               // R9
endmodule

bind adc_seq_ctrl adc_seq_ctrl_sva #(
    .DATA_W     (DATA_W),
    .CNT_W      (CNT_W),
    .CAL_LAST   (CAL_CYCLES - 1),
    .FIRST_LAST (CONV_FIRST - 1),
    .CONT_LAST  (CONV_CONT - 1)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cal_busy  (cal_busy),
    .conv_busy (conv_busy),
    .drdy_n    (drdy_n),
    .ch_sel    (ch_sel),
    .res_out   (res_out),
    .cnt       (cnt)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
    localparam int CALN  = 3246;
    localparam int FIRST = 1624;
    localparam int CONT  = 1622;
    localparam int LEAD  = 82;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cal_req, cnv_req, addr, bipolar, flt_vld;
    logic [19:0] flt_data;
    logic        ch_sel, cal_busy, conv_busy, drdy_n;
    logic [19:0] res_out;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .cnv_req(cnv_req),
        .addr(addr), .bipolar(bipolar), .flt_data(flt_data), .flt_vld(flt_vld),
        .ch_sel(ch_sel), .cal_busy(cal_busy), .conv_busy(conv_busy),
        .drdy_n(drdy_n), .res_out(res_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference model: phase, elapsed cycles, delayed inputs.
    int          m_phase, m_el, m_len;
    bit          m_drdy, m_mode, m_ch, m_edge;
    bit          c1, c2, c3, k1, k2, a1, a2;
    logic [19:0] m_res, m_dout;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_el = 0; m_len = FIRST; m_drdy = 1; m_mode = 0; m_ch = 0;
            c1 = 0; c2 = 0; c3 = 0; k1 = 0; k2 = 0; a1 = 0; a2 = 0;
            m_res = 0; m_dout = 0;
        end else begin
            m_edge = c2 && !c3;
            if (m_phase == 2 && m_el == m_len - 1 - LEAD) m_mode = bipolar;
            if (m_phase == 2 && m_el == 0) m_drdy = 1;
            case (m_phase)
                0: if (m_edge) begin
                       m_ch = a2; m_el = 0; m_len = FIRST;
                       m_phase = k2 ? 1 : 2;
                   end
                1: if (m_edge && k2) begin
                       m_ch = a2; m_el = 0;
                   end else if (m_el == CALN - 1) begin
                       m_el = 0; m_len = FIRST;
                       m_phase = c2 ? 2 : 0;
                   end else m_el++;
                default: if (m_el == m_len - 1) begin
                       m_drdy = 0;
                       m_dout = m_res + (m_mode ? 20'h80000 : 20'h0);
                       m_el = 0; m_len = CONT;
                       if (!c2) m_phase = 0;
                   end else m_el++;
            endcase
            if (flt_vld) m_res = flt_data;
            c3 = c2; c2 = c1; c1 = cnv_req;
            k2 = k1; k1 = cal_req;
            a2 = a1; a1 = addr;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cal_busy == (m_phase == 1), "R2 model cal_busy", cal_busy, m_phase == 1);
            check(conv_busy == (m_phase == 2), "R7 model conv_busy", conv_busy, m_phase == 2);
            check(drdy_n == m_drdy, "R8 model drdy_n", drdy_n, m_drdy);
            check(res_out == m_dout, "R9 model res_out", res_out, m_dout);
            check(ch_sel == m_ch, "R6 model ch_sel", ch_sel, m_ch);
        end
    end

    task automatic push_data(input logic [19:0] d);
        flt_data = d; flt_vld = 1'b1;
        @(negedge clk);
        flt_vld = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        int t0, t1, t2, t3, t4, d1, d2;
        rst_n = 0; cal_req = 0; cnv_req = 0; addr = 0; bipolar = 0;
        flt_data = 0; flt_vld = 0;
        repeat (4) @(negedge clk);
        // R11: reset values
        check(drdy_n == 1 && !cal_busy && !conv_busy && ch_sel == 0 && res_out == 0,
              "R11 reset state", {drdy_n, cal_busy, conv_busy, ch_sel}, 4'b1000);
        rst_n = 1;
        repeat (3) @(negedge clk);
        check(drdy_n == 1 && !cal_busy && !conv_busy, "R11 after reset", drdy_n, 1);

        // Single conversion on input 2, unipolar, with extra edges ignored
        push_data(20'h12345);
        addr = 1; t0 = cyc; cnv_req = 1;
        while (!conv_busy) @(negedge clk);
        t1 = cyc;
        check(t1 - t0 == 3, "R1 conversion start latency", t1 - t0, 3);
        check(ch_sel == 1, "R6 addr 1 selects input 2", ch_sel, 1);
        repeat (100) @(negedge clk); cnv_req = 0;
        repeat (100) @(negedge clk); addr = 0; cnv_req = 1;
        push_data(20'h0ABCD);
        repeat (100) @(negedge clk); cnv_req = 0;
        while (conv_busy) @(negedge clk);
        t2 = cyc;
        check(t2 - t1 == FIRST, "R12 conversion length unaffected", t2 - t1, FIRST);
        check(ch_sel == 1, "R12 ch_sel unaffected", ch_sel, 1);
        check(drdy_n == 0, "R8 drdy falls at end", drdy_n, 0);
        check(res_out == 20'h0ABCD, "R9 unipolar word", res_out, 20'h0ABCD);
        repeat (10) @(negedge clk);
        check(drdy_n == 0, "R8 drdy held low in standby", drdy_n, 0);

        // Bipolar chosen late in the conversion
        push_data(20'h00010);
        addr = 0; bipolar = 0; cnv_req = 1;
        while (!conv_busy) @(negedge clk);
        t1 = cyc;
        check(drdy_n == 0, "R8 drdy still low at start edge", drdy_n, 0);
        @(negedge clk);
        check(drdy_n == 1, "R8 drdy rises after start", drdy_n, 1);
        repeat (10) @(negedge clk); cnv_req = 0;
        repeat (1000) @(negedge clk); bipolar = 1;
        while (conv_busy) @(negedge clk);
        check(ch_sel == 0, "R6 addr 0 selects input 1", ch_sel, 0);
        check(res_out == 20'h80010, "R9 bipolar offset", res_out, 20'h80010);

        // Mode change inside the final 82 cycles has no effect
        push_data(20'hFFFF0);
        cnv_req = 1;
        while (!conv_busy) @(negedge clk);
        repeat (10) @(negedge clk); cnv_req = 0;
        repeat (FIRST - 30) @(negedge clk); bipolar = 0;
        while (conv_busy) @(negedge clk);
        check(res_out == 20'h7FFF0, "R9 late mode change ignored, wraps", res_out, 20'h7FFF0);

        // Calibration, calibrate dropped early, ends in standby
        cal_req = 1; t0 = cyc; cnv_req = 1;
        while (!cal_busy) @(negedge clk);
        t1 = cyc;
        check(t1 - t0 == 3, "R1 calibration start latency", t1 - t0, 3);
        repeat (10) @(negedge clk); cal_req = 0;
        repeat (40) @(negedge clk); cnv_req = 0;
        while (cal_busy) @(negedge clk);
        t2 = cyc;
        check(t2 - t1 == CALN, "R10 R2 calibration length", t2 - t1, CALN);
        check(!conv_busy, "R3 standby after calibration", conv_busy, 0);
        repeat (20) @(negedge clk);

        // Restart of calibration
        cal_req = 1; d1 = cyc; cnv_req = 1;
        while (!cal_busy) @(negedge clk);
        t1 = cyc;
        repeat (1000) @(negedge clk); cnv_req = 0;
        repeat (3) @(negedge clk); d2 = cyc; cnv_req = 1;
        repeat (10) @(negedge clk); cal_req = 0;
        repeat (10) @(negedge clk); cnv_req = 0;
        while (cal_busy) @(negedge clk);
        t2 = cyc;
        check(t2 - t1 == (d2 - d1) + CALN, "R4 calibration restarted", t2 - t1, (d2 - d1) + CALN);
        repeat (20) @(negedge clk);

        // Ignored edge, then chained continuous conversions
        addr = 1; cal_req = 1; cnv_req = 1;
        while (!cal_busy) @(negedge clk);
        t1 = cyc;
        repeat (10) @(negedge clk); cal_req = 0;
        repeat (990) @(negedge clk); cnv_req = 0; addr = 0;
        repeat (3) @(negedge clk); cnv_req = 1;
        push_data(20'h55555);
        while (cal_busy) @(negedge clk);
        t2 = cyc;
        check(t2 - t1 == CALN, "R5 edge ignored, length kept", t2 - t1, CALN);
        check(ch_sel == 1, "R5 ch_sel kept", ch_sel, 1);
        check(conv_busy, "R3 conversion follows calibration", conv_busy, 1);
        @(negedge clk);
        while (drdy_n) @(negedge clk);
        t3 = cyc;
        check(t3 - t2 == FIRST, "R8 first result after calibration", t3 - t2, FIRST);
        check(res_out == 20'h55555, "R9 result after calibration", res_out, 20'h55555);
        @(negedge clk);
        check(drdy_n == 1, "R8 drdy rises in continuous mode", drdy_n, 1);
        while (drdy_n) @(negedge clk);
        t4 = cyc;
        check(t4 - t3 == CONT, "R7 continuous period", t4 - t3, CONT);
        repeat (5) @(negedge clk); cnv_req = 0;
        while (conv_busy) @(negedge clk);
        check(cyc - t4 == CONT, "R7 last continuous conversion", cyc - t4, CONT);
        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule